// File: doc/BRIEF.md
# Write Protection Flag Unit

This unit holds the write-protection state of a small two-wire serial memory. It decides whether each normal byte write may program the array, and it handles the family of protection commands whose header starts with the prefix 0110. Two flags are kept. The permanent lock can only be set and never cleared. The reversible lock can be set and cleared, but only while the A0 pin carries a high-voltage level. A hardware write-protect pin overrides both flags and makes the whole array read-only.

The bus engine sits outside this block. It passes in each received header byte together with the address pin levels and the high-voltage indication on A0. The unit answers every header with ACK or NACK, and that answer depends on the current flag state as well as on the address match. A flag-changing command is held pending until the bus engine reports that the sequence has completed (dummy address byte, dummy data byte and Stop). At that point the unit starts a flag program cycle, but only if the write-protect pin stayed low from the header until completion. For normal writes the unit drives a combinational write-enable from the byte address.

Top module: `wp_guard_unit`

## Requirements
- R1: After reset both flags are 0, `resp_valid` and `prog_start` are 0, and every address is writable while `wp_pin` is low.
- R2: While `wp_pin` is 1, `wr_allow` is 0 for every address.
- R3: Addresses with the MSB set (80h–FFh) have `wr_allow` = 1 whenever `wp_pin` is 0, whatever the flags hold.
- R4: Addresses with the MSB clear (00h–7Fh) have `wr_allow` = 1 only when `wp_pin` is 0 and both the permanent and the reversible flag are 0.
- R5: The header 0110 A2 A1 A0 0 (bits 3..1 equal to the pins, `a0_hv` = 0) sets the permanent lock. It is ACKed while the permanent flag is 0. On `seq_done` the flag is set and `prog_start` pulses, provided `wp_pin` stayed 0 from the header through `seq_done`. Otherwise nothing changes.
- R6: Once the permanent flag is 1, every header with prefix 0110 is NACKed, no program cycle starts, and the flag never returns to 0.
- R7: Reversible commands need `a0_hv` = 1, `pin_a2` = 0 and header bits 0110 0 A1 1 R/W, with bit 2 equal to `pin_a1`. A 0110 header that fails these conditions, or that fails the pin match of R5 when `a0_hv` = 0, is NACKed.
- R8: A reversible set (bit 2 = 0, R/W = 0) or clear (bit 2 = 1, R/W = 0) is ACKed while the permanent flag is 0. On `seq_done` it sets or clears the reversible flag and pulses `prog_start`, but only if `wp_pin` stayed 0 for the whole sequence.
- R9: Status reads cause no program cycle. A read-SWP (reversible, bit 2 = 0, R/W = 1) is ACKed exactly when the reversible flag is 0. A read-CWP (reversible, bit 2 = 1, R/W = 1) and a permanent-status read (R/W = 1, `a0_hv` = 0) are ACKed exactly when the permanent flag is 0.
- R10: A header with prefix 1010 is ACKed when bits 3..1 equal the pins, and NACKed otherwise. Headers with any other prefix are NACKed.
- R11: `resp_valid` and `resp_ack` appear exactly one cycle after the `hdr_valid` cycle.
- R12: A new header discards any pending flag command, so a later `seq_done` starts no program cycle and leaves the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | One-cycle strobe: a header byte has been received |
| hdr_byte | input | 8 | Received header byte: prefix in [7:4], address bits in [3:1], R/W in [0] |
| pin_a2 | input | 1 | Logic level of address pin A2 |
| pin_a1 | input | 1 | Logic level of address pin A1 |
| pin_a0 | input | 1 | Logic level of address pin A0 |
| a0_hv | input | 1 | A0 is driven to the high-voltage level |
| wp_pin | input | 1 | Hardware write-protect level |
| seq_done | input | 1 | One-cycle strobe: the current command ended with a complete sequence and Stop |
| wr_addr | input | ADDR_W | Byte address of a normal write |
| wr_allow | output | 1 | The normal write to `wr_addr` may program the array |
| resp_valid | output | 1 | A header decision is presented |
| resp_ack | output | 1 | 1 = ACK, 0 = NACK for the last header |
| prog_start | output | 1 | One-cycle pulse: a flag program cycle begins |

## Verification
The hardest case to reach is a flag command that is ACKed and completed but still has to be refused, because the write-protect pin rose briefly between the header and completion. The pin is low at both ends, so the value at `seq_done` alone would wrongly allow the change. The stimulus raises `wp_pin` for a single cycle in the middle of a pending set or clear and then drops it before `seq_done`. Afterwards the flag state is probed through `wr_allow` on a lower-half address and through status-read acknowledges. A second hard case is an ACKed flag command abandoned by a fresh header before completion. It is reached by sending a status read between the set header and `seq_done`.

// File: rtl/wp_guard_pkg.sv
package wp_guard_pkg;

    localparam logic [3:0] PFX_NORMAL  = 4'b1010;
    localparam logic [3:0] PFX_PROTECT = 4'b0110;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_NORMAL,
        CMD_SET_PERM,
        CMD_SET_REV,
        CMD_CLR_REV,
        CMD_STATUS
    } cmd_kind_e;

    typedef struct packed {
        cmd_kind_e kind;
        logic      ack;
    } hdr_decision_t;

    typedef struct packed {
        logic a2;
        logic a1;
        logic a0;
        logic hv;
    } pin_state_t;

    function automatic logic is_flag_write(cmd_kind_e k);
        return (k == CMD_SET_PERM) || (k == CMD_SET_REV) || (k == CMD_CLR_REV);
    endfunction

endpackage

// File: rtl/wp_hdr_decode.sv
module wp_hdr_decode
    import wp_guard_pkg::*;
(
    input  logic [7:0]    hdr,
    input  pin_state_t    pins,
    input  logic          perm_flag,
    input  logic          rev_flag,
    output hdr_decision_t dec
);
    logic [3:0] prefix;
    logic [2:0] addr_bits;
    logic       rw_bit;
    logic       pins_match;
    logic       rev_match;

    assign prefix     = hdr[7:4];
    assign addr_bits  = hdr[3:1];
    assign rw_bit     = hdr[0];
    assign pins_match = (addr_bits == {pins.a2, pins.a1, pins.a0});
    assign rev_match  = pins.hv && !pins.a2 && !addr_bits[2] &&
                        (addr_bits[1] == pins.a1) && addr_bits[0];

    always_comb begin
        dec.kind = CMD_NONE;
        dec.ack  = 1'b0;
        if (prefix == PFX_NORMAL) begin
            if (pins_match) begin
                dec.kind = CMD_NORMAL;
                dec.ack  = 1'b1;
            end
        end else if (prefix == PFX_PROTECT && !perm_flag) begin
            if (pins.hv) begin
                if (rev_match) begin
                    unique case ({addr_bits[1], rw_bit})
                        2'b00: begin dec.kind = CMD_SET_REV; dec.ack = 1'b1;      end
                        2'b10: begin dec.kind = CMD_CLR_REV; dec.ack = 1'b1;      end
                        2'b01: begin dec.kind = CMD_STATUS;  dec.ack = !rev_flag; end
                        default: begin dec.kind = CMD_STATUS; dec.ack = 1'b1;     end
                    endcase
                end
            end else if (pins_match) begin
                dec.kind = rw_bit ? CMD_STATUS : CMD_SET_PERM;
                dec.ack  = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wp_flag_store.sv
module wp_flag_store
    import wp_guard_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          hdr_valid,
    input  hdr_decision_t dec,
    input  logic          wp_pin,
    input  logic          seq_done,
    output logic          perm_flag,
    output logic          rev_flag,
    output logic          prog_start
);
    cmd_kind_e pend_kind_q;
    logic      pend_q;
    logic      wp_seen_q;
    logic      perm_q, rev_q, prog_q;
    logic      commit;

    assign commit = seq_done && pend_q && !wp_seen_q && !wp_pin && !hdr_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= 1'b0;
            pend_kind_q <= CMD_NONE;
            wp_seen_q   <= 1'b0;
            perm_q      <= 1'b0;
            rev_q       <= 1'b0;
            prog_q      <= 1'b0;
        end else begin
            prog_q <= commit;
            if (hdr_valid) begin
                pend_q      <= dec.ack && is_flag_write(dec.kind);
                pend_kind_q <= dec.kind;
                wp_seen_q   <= wp_pin;
            end else if (seq_done) begin
                pend_q    <= 1'b0;
                wp_seen_q <= 1'b0;
            end else if (pend_q) begin
                wp_seen_q <= wp_seen_q | wp_pin;
            end
            if (commit) begin
                unique case (pend_kind_q)
                    CMD_SET_PERM: perm_q <= 1'b1;
                    CMD_SET_REV:  rev_q  <= 1'b1;
                    CMD_CLR_REV:  rev_q  <= 1'b0;
                    default: ;
                endcase
            end
        end
    end

    assign perm_flag  = perm_q;
    assign rev_flag   = rev_q;
    assign prog_start = prog_q;

    p_perm_sticky_r6: assert property (@(posedge clk) disable iff (rst)
        perm_q |=> perm_q);
    p_prog_after_done_r5: assert property (@(posedge clk) disable iff (rst)
        prog_q |-> $past(seq_done));
    p_rev_moves_with_prog_r8: assert property (@(posedge clk) disable iff (rst)
        !$stable(rev_q) |-> prog_q);
    p_perm_moves_with_prog_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(perm_q) |-> prog_q);
endmodule

// File: rtl/wp_write_gate.sv
module wp_write_gate #(
    parameter int ADDR_W = 8
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wp_pin,
    input  logic              perm_flag,
    input  logic              rev_flag,
    output logic              allow
);
    localparam int TOP_BIT = ADDR_W - 1;

    logic upper_half;
    logic lower_locked;

    assign upper_half   = addr[TOP_BIT];
    assign lower_locked = perm_flag | rev_flag;
    assign allow        = !wp_pin && (upper_half || !lower_locked);
endmodule

// File: rtl/wp_guard_unit.sv
module wp_guard_unit
    import wp_guard_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hdr_valid,
    input  logic [7:0]        hdr_byte,
    input  logic              pin_a2,
    input  logic              pin_a1,
    input  logic              pin_a0,
    input  logic              a0_hv,
    input  logic              wp_pin,
    input  logic              seq_done,
    input  logic [ADDR_W-1:0] wr_addr,
    output logic              wr_allow,
    output logic              resp_valid,
    output logic              resp_ack,
    output logic              prog_start
);
    pin_state_t    pins;
    hdr_decision_t dec;
    logic          perm_flag, rev_flag;
    logic          resp_valid_q, resp_ack_q;

    assign pins = '{a2: pin_a2, a1: pin_a1, a0: pin_a0, hv: a0_hv};

    wp_hdr_decode u_decode (
        .hdr       (hdr_byte),
        .pins      (pins),
        .perm_flag (perm_flag),
        .rev_flag  (rev_flag),
        .dec       (dec)
    );

    wp_flag_store u_flags (
        .clk        (clk),
        .rst        (rst),
        .hdr_valid  (hdr_valid),
        .dec        (dec),
        .wp_pin     (wp_pin),
        .seq_done   (seq_done),
        .perm_flag  (perm_flag),
        .rev_flag   (rev_flag),
        .prog_start (prog_start)
    );

    wp_write_gate #(.ADDR_W(ADDR_W)) u_gate (
        .addr      (wr_addr),
        .wp_pin    (wp_pin),
        .perm_flag (perm_flag),
        .rev_flag  (rev_flag),
        .allow     (wr_allow)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid_q <= 1'b0;
            resp_ack_q   <= 1'b0;
        end else begin
            resp_valid_q <= hdr_valid;
            resp_ack_q   <= hdr_valid && dec.ack;
        end
    end

    assign resp_valid = resp_valid_q;
    assign resp_ack   = resp_ack_q;

    p_resp_follows_hdr_r11: assert property (@(posedge clk) disable iff (rst)
        hdr_valid |=> resp_valid);
    p_wp_blocks_all_r2: assert property (@(posedge clk) disable iff (rst)
        wp_pin |-> !wr_allow);
    p_locked_nacks_r6: assert property (@(posedge clk) disable iff (rst)
        (hdr_valid && perm_flag && hdr_byte[7:4] == PFX_PROTECT) |=> !resp_ack);
    p_ack_needs_resp_r11: assert property (@(posedge clk) disable iff (rst)
        resp_ack |-> resp_valid);
endmodule

// File: tb/wp_guard_unit_bench.sv
module wp_guard_unit_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hdr_valid = 1'b0;
    logic [7:0] hdr_byte = 8'h00;
    logic       pin_a2 = 1'b0, pin_a1 = 1'b0, pin_a0 = 1'b0, a0_hv = 1'b0;
    logic       wp_pin = 1'b0;
    logic       seq_done = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic       wr_allow, resp_valid, resp_ack, prog_start;

    int checks = 0;
    int failures = 0;
    bit exp_q[$];
    string tag_q[$];
    bit finished = 1'b0;

    always #4 clk = ~clk;

    wp_guard_unit u_wp_guard_unit (
        .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
        .pin_a2(pin_a2), .pin_a1(pin_a1), .pin_a0(pin_a0), .a0_hv(a0_hv),
        .wp_pin(wp_pin), .seq_done(seq_done), .wr_addr(wr_addr),
        .wr_allow(wr_allow), .resp_valid(resp_valid), .resp_ack(resp_ack),
        .prog_start(prog_start)
    );

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // monitor: pops the scoreboard whenever a response appears
    always @(negedge clk) begin
        if (!rst && !finished && resp_valid) begin
            if (exp_q.size() == 0) begin
                check("R11 unexpected response", 1'b1, 1'b0);
            end else begin
                automatic bit    e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(t, resp_ack, e);
            end
        end
    end

    task automatic send_hdr(input logic [7:0] h, input bit exp_ack, input string tag);
        @(negedge clk);
        hdr_byte  = h;
        hdr_valid = 1'b1;
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        @(negedge clk);
        hdr_valid = 1'b0;
    endtask

    task automatic finish_cmd(input bit wp_mid, input bit exp_prog, input string tag);
        @(negedge clk);
        wp_pin = wp_mid;
        @(negedge clk);
        wp_pin = 1'b0;
        seq_done = 1'b1;
        @(negedge clk);
        seq_done = 1'b0;
        check(tag, prog_start, exp_prog);
        @(negedge clk);
        check({tag, " single pulse"}, prog_start, 1'b0);
    endtask

    task automatic probe(input logic [7:0] a, input logic exp, input string tag);
        @(negedge clk);
        wr_addr = a;
        #1;
        check(tag, wr_allow, exp);
    endtask

    task automatic set_pins(input logic a2, input logic a1, input logic a0, input logic hv);
        pin_a2 = a2; pin_a1 = a1; pin_a0 = a0; a0_hv = hv;
    endtask

    initial begin
        #(8 * 20000);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 resp_valid", resp_valid, 1'b0);
        check("R1 prog_start", prog_start, 1'b0);
        probe(8'h10, 1'b1, "R1 lower writable");
        probe(8'h90, 1'b1, "R3 upper writable");
        // R2 hardware lock
        wp_pin = 1'b1;
        probe(8'h10, 1'b0, "R2 lower blocked");
        probe(8'hF0, 1'b0, "R2 upper blocked");
        wp_pin = 1'b0;

        // R10 normal headers, pins A2=1 A1=0 A0=1
        set_pins(1'b1, 1'b0, 1'b1, 1'b0);
        send_hdr(8'b1010_101_0, 1'b1, "R10 normal match");
        send_hdr(8'b1010_100_0, 1'b0, "R10 normal mismatch");
        send_hdr(8'b1100_101_0, 1'b0, "R10 foreign prefix");
        // R9 permanent status read, R7 mismatched pins
        send_hdr(8'b0110_101_1, 1'b1, "R9 read perm while clear");
        send_hdr(8'b0110_111_1, 1'b0, "R7 perm header mismatch");
        send_hdr(8'b0110_101_1, 1'b1, "R9 status gives no prog");
        finish_cmd(1'b0, 1'b0, "R9 status no prog cycle");

        // R8 set reversible: A2=0 A1=0 HV
        set_pins(1'b0, 1'b0, 1'b1, 1'b1);
        send_hdr(8'b0110_001_0, 1'b1, "R8 set rev ack");
        finish_cmd(1'b0, 1'b1, "R8 set rev prog");
        probe(8'h10, 1'b0, "R4 lower locked by rev");
        probe(8'h80, 1'b1, "R3 upper still open");
        send_hdr(8'b0110_001_1, 1'b0, "R9 read SWP when set");
        set_pins(1'b0, 1'b1, 1'b1, 1'b1);
        send_hdr(8'b0110_011_1, 1'b1, "R9 read CWP perm clear");

        // R7 qualifier errors
        send_hdr(8'b0110_001_0, 1'b0, "R7 bit2 vs A1 mismatch");
        set_pins(1'b1, 1'b1, 1'b1, 1'b1);
        send_hdr(8'b0110_011_0, 1'b0, "R7 A2 pin high");
        set_pins(1'b0, 1'b1, 1'b0, 1'b0);
        send_hdr(8'b0110_011_0, 1'b0, "R7 no high voltage");

        // R8 clear with write-protect pulse mid-sequence
        set_pins(1'b0, 1'b1, 1'b1, 1'b1);
        send_hdr(8'b0110_011_0, 1'b1, "R8 clear rev ack");
        finish_cmd(1'b1, 1'b0, "R8 clear blocked by wp");
        probe(8'h10, 1'b0, "R8 rev still set");
        send_hdr(8'b0110_011_0, 1'b1, "R8 clear rev ack again");
        finish_cmd(1'b0, 1'b1, "R8 clear rev prog");
        probe(8'h10, 1'b1, "R4 lower open again");

        // R12 abandoned command
        set_pins(1'b0, 1'b0, 1'b1, 1'b1);
        send_hdr(8'b0110_001_0, 1'b1, "R12 set rev ack");
        send_hdr(8'b0110_001_1, 1'b1, "R12 read SWP clear");
        finish_cmd(1'b0, 1'b0, "R12 no prog after new header");
        probe(8'h10, 1'b1, "R12 flags unchanged");

        // R5 set permanent, blocked then effective
        set_pins(1'b1, 1'b0, 1'b1, 1'b0);
        send_hdr(8'b0110_101_0, 1'b1, "R5 set perm ack");
        finish_cmd(1'b1, 1'b0, "R5 blocked by wp");
        probe(8'h10, 1'b1, "R5 perm still clear");
        send_hdr(8'b0110_101_0, 1'b1, "R5 set perm ack again");
        finish_cmd(1'b0, 1'b1, "R5 perm prog");
        probe(8'h10, 1'b0, "R4 lower locked by perm");
        probe(8'hC0, 1'b1, "R3 upper open under perm");

        // R6 everything 0110 refused
        send_hdr(8'b0110_101_1, 1'b0, "R6 read perm nack");
        send_hdr(8'b0110_101_0, 1'b0, "R6 set perm nack");
        send_hdr(8'b1010_101_1, 1'b1, "R10 normal still acked");
        set_pins(1'b0, 1'b1, 1'b1, 1'b1);
        send_hdr(8'b0110_011_0, 1'b0, "R6 clear rev nack");
        finish_cmd(1'b0, 1'b0, "R6 no prog when locked");
        probe(8'h10, 1'b0, "R6 perm never clears");
        set_pins(1'b0, 1'b0, 1'b1, 1'b1);
        send_hdr(8'b0110_001_1, 1'b0, "R6 read SWP nack");

        repeat (3) @(negedge clk);
        check("R11 scoreboard drained", exp_q.size() == 0, 1'b1);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule